// File: doc/BRIEF.md
# Rotating Interrupt Priority Resolver

This block is the priority and in-service core of one eight-input legacy interrupt controller. It holds the request, in-service and mask registers, plus a pointer to the pin that currently has the lowest priority. Priority is resolved by walking the pins in order, starting at the pin just above that pointer and wrapping around. From this walk it reports the best eligible pending request. It also finds the highest-priority in-service pin, which a non-specific end-of-interrupt needs.

Decoded command strobes drive the block. These strobes cover end-of-interrupt (specific or non-specific), rotation, setting the lowest-priority pin, writing the mask and the special mask mode. An acknowledge strobe carries the pin that the processor accepted. Two static mode inputs select auto end-of-interrupt and special fully-nested operation. Bus decoding, edge detection on the request lines and cascading between controllers are left to the surrounding logic.

Top module: `rot_prio_resolver`

## Requirements
- R1: A synchronous active-high reset clears the request, in-service and mask registers, sets the lowest-priority pointer to NUM_PINS-1, and turns rotation and special mask mode off. After reset, pin 0 has the highest priority.
- R2: The pending output is the first eligible pin met while scanning upward from (pointer+1) mod NUM_PINS and wrapping. A pin is eligible when its request bit is 1 and its mask bit is 0. `pend_valid` is 0 when no pin qualifies.
- R3: A set in-service bit ends the scan with no result at that pin. No request at the same priority as that pin, or at any lower priority, can win.
- R4: While special mask mode is on, in-service bits have no effect on the pending choice. Only the mask limits it.
- R5: While `sfnm_en` is 1, the in-service bit of the cascade pin (CASCADE_PIN, default 2) does not block the scan.
- R6: A non-specific end-of-interrupt (`cmd_eoi`=1, `cmd_sel`=0) clears the highest-priority set in-service bit. In special mask mode it skips in-service bits whose mask bit is 1. With rotation on, the cleared pin becomes the lowest-priority pin.
- R7: A specific end-of-interrupt (`cmd_eoi`=1, `cmd_sel`=1) clears the in-service bit numbered `cmd_lvl`. With rotation on, that pin becomes the lowest-priority pin.
- R8: Every command write loads the rotation flag from `cmd_rot`. A command with `cmd_sel`=1 and `cmd_eoi`=0 sets the pointer to `cmd_lvl` only when the new rotation flag is 1. Otherwise it leaves the pointer unchanged. The pointer changes only on a command or an acknowledge.
- R9: On acknowledge of `ack_pin`, the request bit clears only if `line_high` for that pin is 0. Without auto end-of-interrupt, the in-service bit of the pin is set. With auto end-of-interrupt, no in-service bit is set, and the pointer moves to the pin when rotation is on.
- R10: When an end-of-interrupt and an acknowledge arrive in the same cycle, the end-of-interrupt is applied first. A specific end-of-interrupt of pin p combined with an acknowledge of p therefore leaves in-service bit p set.
- R11: `irr_set` bits set request bits on the next edge, taking precedence over an acknowledge clear. `mask_we` loads the mask from `mask_wdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irr_set | input | NUM_PINS | Per-pin request set pulses |
| line_high | input | NUM_PINS | Current level of each request line |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | NUM_PINS | New mask value |
| cmd_we | input | 1 | Priority/EOI command strobe |
| cmd_eoi | input | 1 | Command is an end-of-interrupt |
| cmd_sel | input | 1 | Command uses `cmd_lvl` |
| cmd_rot | input | 1 | Rotation flag carried by the command |
| cmd_lvl | input | PIN_W | Pin number carried by the command |
| smm_we | input | 1 | Special mask mode write strobe |
| smm_en | input | 1 | New special mask mode value |
| sfnm_en | input | 1 | Special fully-nested mode |
| aeoi_en | input | 1 | Auto end-of-interrupt mode |
| ack_we | input | 1 | Interrupt acknowledge strobe |
| ack_pin | input | PIN_W | Acknowledged pin |
| pend_valid | output | 1 | An eligible request exists |
| pend_pin | output | PIN_W | Winning pending pin |
| isr_out | output | NUM_PINS | In-service register |
| irr_out | output | NUM_PINS | Request register |
| imr_out | output | NUM_PINS | Mask register |
| low_prio | output | PIN_W | Lowest-priority pointer |

## Verification
The bench targets wrap-around when the pointer sits mid-range. A resolver that always scanned from pin 0 would report the wrong winner there. It checks that a masked or lower request is still blocked by a higher in-service pin, and that special mask mode and special fully-nested mode each lift exactly the intended blocking. A design that mishandled either would raise requests too early or hide them. It drives a non-specific end-of-interrupt in special mask mode with a masked in-service bit; a wrong design would clear the masked bit. It drives a specific end-of-interrupt and an acknowledge of the same pin in one cycle; applying them in the wrong order would leave the in-service bit clear. It also checks that a select command with rotation off leaves the pointer unmoved.

// File: rtl/rpr_pkg.sv
package rpr_pkg;

   typedef enum logic [1:0] {
      CMD_IDLE     = 2'd0,
      CMD_EOI_AUTO = 2'd1,
      CMD_EOI_PIN  = 2'd2,
      CMD_SET_LOW  = 2'd3
   } cmd_kind_e;

   function automatic cmd_kind_e decode_cmd(input logic we, input logic eoi,
                                            input logic sel);
      cmd_kind_e k;
      k = CMD_IDLE;
      if (we) begin
         if (eoi) k = sel ? CMD_EOI_PIN : CMD_EOI_AUTO;
         else if (sel) k = CMD_SET_LOW;
      end
      return k;
   endfunction

endpackage

// File: rtl/rpr_scan.sv
module rpr_scan #(
   parameter int NUM_PINS = 8,
   localparam int PIN_W = $clog2(NUM_PINS)
) (
   input  logic [NUM_PINS-1:0] hit,
   input  logic [NUM_PINS-1:0] stop,
   input  logic [PIN_W-1:0]    base,
   output logic                found,
   output logic [PIN_W-1:0]    pin
);
   logic [2*NUM_PINS-1:0] hit_dbl, stop_dbl;
   logic [NUM_PINS-1:0]   hit_rot, stop_rot;
   logic                  blocked;

   always_comb begin
      hit_dbl  = {hit, hit} >> (int'(base) + 1);
      stop_dbl = {stop, stop} >> (int'(base) + 1);
      hit_rot  = hit_dbl[NUM_PINS-1:0];
      stop_rot = stop_dbl[NUM_PINS-1:0];
      found    = 1'b0;
      blocked  = 1'b0;
      pin      = '0;
      for (int i = 0; i < NUM_PINS; i++) begin
         if (!found && !blocked) begin
            if (stop_rot[i]) begin
               blocked = 1'b1;
            end else if (hit_rot[i]) begin
               found = 1'b1;
               pin   = PIN_W'(i) + base + PIN_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/rpr_cmd_unit.sv
module rpr_cmd_unit
   import rpr_pkg::*;
#(
   parameter int NUM_PINS = 8,
   localparam int PIN_W = $clog2(NUM_PINS)
) (
   input  logic                cmd_we,
   input  logic                cmd_eoi,
   input  logic                cmd_sel,
   input  logic                cmd_rot,
   input  logic [PIN_W-1:0]    cmd_lvl,
   input  logic                rot_cur,
   input  logic [NUM_PINS-1:0] isr_cur,
   input  logic [PIN_W-1:0]    low_cur,
   input  logic                hi_valid,
   input  logic [PIN_W-1:0]    hi_pin,
   output logic                rot_nxt,
   output logic [NUM_PINS-1:0] isr_nxt,
   output logic [PIN_W-1:0]    low_nxt
);
   cmd_kind_e           kind;
   logic                clr_hit;
   logic [PIN_W-1:0]    clr_pin;

   always_comb begin
      kind    = decode_cmd(cmd_we, cmd_eoi, cmd_sel);
      rot_nxt = cmd_we ? cmd_rot : rot_cur;
      isr_nxt = isr_cur;
      low_nxt = low_cur;
      clr_hit = 1'b0;
      clr_pin = cmd_lvl;
      unique case (kind)
         CMD_EOI_PIN:  clr_hit = 1'b1;
         CMD_EOI_AUTO: begin
            clr_hit = hi_valid;
            clr_pin = hi_pin;
         end
         CMD_SET_LOW:  if (rot_nxt) low_nxt = cmd_lvl;
         default:      ;
      endcase
      if (clr_hit) begin
         isr_nxt[clr_pin] = 1'b0;
         if (rot_nxt) low_nxt = clr_pin;
      end
   end
endmodule

// File: rtl/rot_prio_resolver.sv
module rot_prio_resolver #(
   parameter int NUM_PINS    = 8,
   parameter int CASCADE_PIN = 2,
   parameter bit HAS_CASCADE = 1'b1,
   localparam int PIN_W = $clog2(NUM_PINS)
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [NUM_PINS-1:0] irr_set,
   input  logic [NUM_PINS-1:0] line_high,
   input  logic                mask_we,
   input  logic [NUM_PINS-1:0] mask_wdata,
   input  logic                cmd_we,
   input  logic                cmd_eoi,
   input  logic                cmd_sel,
   input  logic                cmd_rot,
   input  logic [PIN_W-1:0]    cmd_lvl,
   input  logic                smm_we,
   input  logic                smm_en,
   input  logic                sfnm_en,
   input  logic                aeoi_en,
   input  logic                ack_we,
   input  logic [PIN_W-1:0]    ack_pin,
   output logic                pend_valid,
   output logic [PIN_W-1:0]    pend_pin,
   output logic [NUM_PINS-1:0] isr_out,
   output logic [NUM_PINS-1:0] irr_out,
   output logic [NUM_PINS-1:0] imr_out,
   output logic [PIN_W-1:0]    low_prio
);
   localparam logic [PIN_W-1:0] LOW_RESET = PIN_W'(NUM_PINS - 1);

   generate
      if (NUM_PINS < 2 || (NUM_PINS & (NUM_PINS - 1)) != 0) begin : g_bad_pins
         $error("NUM_PINS must be a power of two of at least 2");
      end
      if (HAS_CASCADE && (CASCADE_PIN < 0 || CASCADE_PIN >= NUM_PINS)) begin : g_bad_casc
         $error("CASCADE_PIN out of range");
      end
   endgenerate

   logic [NUM_PINS-1:0] irr_q, isr_q, imr_q;
   logic [PIN_W-1:0]    low_q;
   logic                rot_q, smm_q;

   // in-service bits that may block a pending request
   logic [NUM_PINS-1:0] casc_ignore;
   logic [NUM_PINS-1:0] block_vec;

   generate
      if (HAS_CASCADE) begin : g_casc
         always_comb begin
            casc_ignore = '0;
            casc_ignore[CASCADE_PIN] = sfnm_en;
         end
      end else begin : g_nocasc
         assign casc_ignore = '0;
      end
   endgenerate

   assign block_vec = smm_q ? '0 : (isr_q & ~casc_ignore);

   rpr_scan #(.NUM_PINS(NUM_PINS)) u_pend_scan (
      .hit   (irr_q & ~imr_q),
      .stop  (block_vec),
      .base  (low_q),
      .found (pend_valid),
      .pin   (pend_pin)
   );

   logic             hi_valid;
   logic [PIN_W-1:0] hi_pin;

   rpr_scan #(.NUM_PINS(NUM_PINS)) u_isr_scan (
      .hit   (smm_q ? (isr_q & ~imr_q) : isr_q),
      .stop  ('0),
      .base  (low_q),
      .found (hi_valid),
      .pin   (hi_pin)
   );

   logic                rot_c;
   logic [NUM_PINS-1:0] isr_c;
   logic [PIN_W-1:0]    low_c;

   rpr_cmd_unit #(.NUM_PINS(NUM_PINS)) u_cmd (
      .cmd_we   (cmd_we),
      .cmd_eoi  (cmd_eoi),
      .cmd_sel  (cmd_sel),
      .cmd_rot  (cmd_rot),
      .cmd_lvl  (cmd_lvl),
      .rot_cur  (rot_q),
      .isr_cur  (isr_q),
      .low_cur  (low_q),
      .hi_valid (hi_valid),
      .hi_pin   (hi_pin),
      .rot_nxt  (rot_c),
      .isr_nxt  (isr_c),
      .low_nxt  (low_c)
   );

   // acknowledge stage, applied after the command stage
   logic [NUM_PINS-1:0] isr_n, irr_clr;
   logic [PIN_W-1:0]    low_n;

   always_comb begin
      isr_n   = isr_c;
      low_n   = low_c;
      irr_clr = '0;
      if (ack_we) begin
         irr_clr[ack_pin] = ~line_high[ack_pin];
         if (aeoi_en) begin
            if (rot_c) low_n = ack_pin;
         end else begin
            isr_n[ack_pin] = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         irr_q <= '0;
         isr_q <= '0;
         imr_q <= '0;
         low_q <= LOW_RESET;
         rot_q <= 1'b0;
         smm_q <= 1'b0;
      end else begin
         irr_q <= (irr_q & ~irr_clr) | irr_set;
         isr_q <= isr_n;
         low_q <= low_n;
         rot_q <= rot_c;
         if (mask_we) imr_q <= mask_wdata;
         if (smm_we)  smm_q <= smm_en;
      end
   end

   assign isr_out  = isr_q;
   assign irr_out  = irr_q;
   assign imr_out  = imr_q;
   assign low_prio = low_q;

endmodule

// File: rtl/rpr_checker.sv
module rpr_checker #(
   parameter int NUM_PINS = 8,
   localparam int PIN_W = $clog2(NUM_PINS)
) (
   input logic                clk,
   input logic                rst,
   input logic                cmd_we,
   input logic                cmd_eoi,
   input logic                cmd_sel,
   input logic [PIN_W-1:0]    cmd_lvl,
   input logic                aeoi_en,
   input logic                ack_we,
   input logic [PIN_W-1:0]    ack_pin,
   input logic                pend_valid,
   input logic [PIN_W-1:0]    pend_pin,
   input logic [NUM_PINS-1:0] isr_out,
   input logic [NUM_PINS-1:0] irr_out,
   input logic [NUM_PINS-1:0] imr_out,
   input logic [PIN_W-1:0]    low_prio
);
   logic rst_d = 1'b0;
   always_ff @(posedge clk) rst_d <= rst;

   always_ff @(posedge clk) begin
      if (rst_d === 1'b1 && rst === 1'b0)
         AST_RESET_STATE: assert (isr_out == '0 && irr_out == '0 && imr_out == '0
                                  && low_prio == PIN_W'(NUM_PINS - 1)); // R1
   end

   AST_PEND_ELIGIBLE: assert property (@(posedge clk) disable iff (rst)
      pend_valid |-> (irr_out[pend_pin] && !imr_out[pend_pin])); // R2

   AST_SPEC_EOI_CLEARS: assert property (@(posedge clk) disable iff (rst)
      (cmd_we && cmd_eoi && cmd_sel && !(ack_we && !aeoi_en && ack_pin == cmd_lvl))
      |=> !isr_out[$past(cmd_lvl)]); // R7

   AST_LOW_HOLDS: assert property (@(posedge clk) disable iff (rst)
      (!cmd_we && !ack_we) |=> $stable(low_prio)); // R8

   AST_ACK_SETS_ISR: assert property (@(posedge clk) disable iff (rst)
      (ack_we && !aeoi_en) |=> isr_out[$past(ack_pin)]); // R9

   AST_AEOI_NO_NEW_ISR: assert property (@(posedge clk) disable iff (rst)
      (ack_we && aeoi_en) |=> ((isr_out & ~$past(isr_out)) == '0)); // R9

endmodule

bind rot_prio_resolver rpr_checker #(.NUM_PINS(NUM_PINS)) u_rpr_checker (
   .clk        (clk),
   .rst        (rst),
   .cmd_we     (cmd_we),
   .cmd_eoi    (cmd_eoi),
   .cmd_sel    (cmd_sel),
   .cmd_lvl    (cmd_lvl),
   .aeoi_en    (aeoi_en),
   .ack_we     (ack_we),
   .ack_pin    (ack_pin),
   .pend_valid (pend_valid),
   .pend_pin   (pend_pin),
   .isr_out    (isr_out),
   .irr_out    (irr_out),
   .imr_out    (imr_out),
   .low_prio   (low_prio)
);

// File: tb/rot_prio_resolver_test.sv
module rot_prio_resolver_test;
   localparam int N = 8;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] irr_set = '0, line_high = '0, mask_wdata = '0;
   logic       mask_we = 0, cmd_we = 0, cmd_eoi = 0, cmd_sel = 0, cmd_rot = 0;
   logic [2:0] cmd_lvl = '0, ack_pin = '0;
   logic       smm_we = 0, smm_en = 0, sfnm_en = 0, aeoi_en = 0, ack_we = 0;
   logic       pend_valid;
   logic [2:0] pend_pin, low_prio;
   logic [7:0] isr_out, irr_out, imr_out;

   int total = 0;
   int bad   = 0;

   // reference state
   logic [7:0] m_irr, m_isr, m_imr;
   int         m_low;
   bit         m_rot, m_smm;

   always #4 clk = ~clk;

   rot_prio_resolver uut (
      .clk(clk), .rst(rst), .irr_set(irr_set), .line_high(line_high),
      .mask_we(mask_we), .mask_wdata(mask_wdata), .cmd_we(cmd_we),
      .cmd_eoi(cmd_eoi), .cmd_sel(cmd_sel), .cmd_rot(cmd_rot), .cmd_lvl(cmd_lvl),
      .smm_we(smm_we), .smm_en(smm_en), .sfnm_en(sfnm_en), .aeoi_en(aeoi_en),
      .ack_we(ack_we), .ack_pin(ack_pin), .pend_valid(pend_valid),
      .pend_pin(pend_pin), .isr_out(isr_out), .irr_out(irr_out),
      .imr_out(imr_out), .low_prio(low_prio)
   );

   task automatic chk(input string tag, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // priority order walk: pin numbers beginning just above the pointer
   function automatic int model_pending();
      logic [7:0] blockers;
      blockers = m_smm ? 8'h00 : (m_isr & ~(sfnm_en ? 8'h04 : 8'h00));
      for (int k = 0; k < N; k++) begin
         int p = (m_low + 1 + k) % N;
         if (blockers[p]) return -1;
         if (m_irr[p] && !m_imr[p]) return p;
      end
      return -1;
   endfunction

   function automatic int model_isr_top();
      for (int k = 0; k < N; k++) begin
         int p = (m_low + 1 + k) % N;
         if (m_isr[p] && !(m_smm && m_imr[p])) return p;
      end
      return -1;
   endfunction

   task automatic model_reset();
      m_irr = 0; m_isr = 0; m_imr = 0; m_low = N - 1; m_rot = 0; m_smm = 0;
   endtask

   task automatic model_advance();
      bit         rn;
      logic [7:0] ni, nr;
      int         nl, p;
      rn = cmd_we ? cmd_rot : m_rot;
      ni = m_isr; nl = m_low; nr = m_irr;
      if (cmd_we && cmd_eoi) begin
         p = cmd_sel ? int'(cmd_lvl) : model_isr_top();
         if (p >= 0) begin
            ni[p] = 1'b0;
            if (rn) nl = p;
         end
      end else if (cmd_we && cmd_sel && rn) begin
         nl = cmd_lvl;
      end
      if (ack_we) begin
         if (!line_high[ack_pin]) nr[ack_pin] = 1'b0;
         if (aeoi_en) begin
            if (rn) nl = ack_pin;
         end else ni[ack_pin] = 1'b1;
      end
      nr = nr | irr_set;
      m_irr = nr; m_isr = ni; m_low = nl; m_rot = rn;
      if (mask_we) m_imr = mask_wdata;
      if (smm_we)  m_smm = smm_en;
   endtask

   // one clock: compare combinational result, advance, compare registers
   task automatic step(input string tag);
      int ep;
      #1;
      ep = model_pending();
      chk(tag, "pend_valid", int'(pend_valid), int'(ep >= 0));
      if (ep >= 0) chk(tag, "pend_pin", int'(pend_pin), ep);
      model_advance();
      @(posedge clk);
      #1;
      chk(tag, "irr", int'(irr_out), int'(m_irr));
      chk(tag, "isr", int'(isr_out), int'(m_isr));
      chk(tag, "imr", int'(imr_out), int'(m_imr));
      chk(tag, "low", int'(low_prio), m_low);
      @(negedge clk);
      irr_set = '0; mask_we = 0; cmd_we = 0; cmd_eoi = 0; cmd_sel = 0;
      cmd_rot = 0; smm_we = 0; ack_we = 0;
   endtask

   task automatic do_cmd(input bit eoi, input bit sel, input bit rot, input int lvl);
      cmd_we = 1; cmd_eoi = eoi; cmd_sel = sel; cmd_rot = rot; cmd_lvl = 3'(lvl);
   endtask

   initial begin
      #(8 * 200000);
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst = 0;
      // R1 reset state, pin 0 highest
      chk("R1", "low", int'(low_prio), 7);
      chk("R1", "isr", int'(isr_out), 0);
      step("R1");
      line_high = 8'hFF;
      irr_set = 8'h28; step("R11");
      step("R2");                            // pend 3
      mask_we = 1; mask_wdata = 8'h08; step("R11");
      step("R2");                            // pend 5
      ack_we = 1; ack_pin = 5; step("R9");
      chk("R9", "isr after ack", int'(isr_out), 8'h20);
      chk("R9", "irr kept while line high", int'(irr_out[5]), 1);
      step("R3");                            // 5 in service, 3 masked: none
      chk("R3", "blocked by isr", int'(pend_valid), 0);
      mask_we = 1; mask_wdata = 8'h00; step("R3");
      irr_set = 8'h40; step("R3");
      line_high = 8'hF7;
      ack_we = 1; ack_pin = 3; step("R9");
      chk("R9", "irr cleared when line low", int'(irr_out[3]), 0);
      step("R3");
      chk("R3", "lower pins blocked", int'(pend_valid), 0);
      smm_we = 1; smm_en = 1; step("R4");
      step("R4");
      chk("R4", "smm pend", int'(pend_pin), 5);
      mask_we = 1; mask_wdata = 8'h08; step("R6");
      do_cmd(1, 0, 0, 0); step("R6");
      chk("R6", "masked isr skipped", int'(isr_out), 8'h08);
      smm_we = 1; smm_en = 0; mask_we = 1; mask_wdata = 8'h00; step("R4");
      do_cmd(1, 0, 0, 0); step("R6");
      chk("R6", "nonspecific eoi", int'(isr_out), 8'h00);
      do_cmd(0, 1, 1, 4); step("R8");
      chk("R8", "set low", int'(low_prio), 4);
      do_cmd(0, 1, 0, 1); step("R8");
      chk("R8", "no rotate no move", int'(low_prio), 4);
      irr_set = 8'h41; step("R2");
      step("R2");
      chk("R2", "wrapped scan", int'(pend_pin), 5);
      ack_we = 1; ack_pin = 5; step("R9");
      do_cmd(1, 1, 1, 5); step("R7");
      chk("R7", "spec eoi rotates", int'(low_prio), 5);
      chk("R7", "spec eoi clears", int'(isr_out[5]), 0);
      do_cmd(0, 1, 1, 7); step("R8");
      do_cmd(0, 0, 0, 0); step("R8");
      irr_set = 8'h0C; step("R5");
      ack_we = 1; ack_pin = 2; step("R5");
      mask_we = 1; mask_wdata = 8'hF7; step("R5");
      step("R5");
      chk("R5", "cascade blocks", int'(pend_valid), 0);
      sfnm_en = 1; step("R5");
      #1 chk("R5", "cascade bypass", int'(pend_pin), 3);
      chk("R5", "cascade bypass valid", int'(pend_valid), 1);
      aeoi_en = 1; do_cmd(0, 0, 1, 0); step("R9");
      ack_we = 1; ack_pin = 3; step("R9");
      chk("R9", "aeoi moves low", int'(low_prio), 3);
      chk("R9", "aeoi no isr", int'(isr_out[3]), 0);
      aeoi_en = 0; do_cmd(0, 0, 0, 0); step("R9");
      ack_we = 1; ack_pin = 3; do_cmd(1, 1, 0, 3); step("R10");
      chk("R10", "eoi before ack", int'(isr_out[3]), 1);
      sfnm_en = 0;
      // mixed traffic against the reference model
      for (int it = 0; it < 600; it++) begin
         irr_set   = 8'($urandom) & 8'($urandom);
         line_high = 8'($urandom);
         mask_we   = ($urandom % 6) == 0; mask_wdata = 8'($urandom) & 8'($urandom);
         if ($urandom % 3 == 0) do_cmd(1'($urandom), 1'($urandom), 1'($urandom), int'($urandom % 8));
         smm_we = ($urandom % 10) == 0; smm_en = 1'($urandom);
         sfnm_en = ($urandom % 4) == 0; aeoi_en = ($urandom % 5) == 0;
         ack_we = ($urandom % 3) == 0; ack_pin = 3'($urandom);
         step((it % 2) == 0 ? "R6" : "R10");
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule